// File: doc/BRIEF.md
# Privileged Instruction and I/O Guard

This block sits beside the instruction decoder. For each decoded instruction it decides whether the instruction may run at the current privilege level. Privilege levels run from 0 to 3, and 0 is the most privileged. The decoder supplies these inputs with a one-cycle request strobe:

- a 3-bit instruction class;
- the 16-bit I/O port number;
- the current privilege level (CPL);
- the 2-bit I/O privilege field taken from the flags register (IOPL).

One clock later the block returns either allow or fault, together with a cause code.

Three independent rules apply, each to its own instruction classes:

- System-control instructions need CPL 0.
- Interrupt enable and disable need CPL no greater than IOPL.
- Port input/output is checked against a 65536-bit protection map. The map holds one bit per port and is stored as 4096 words of 16 bits. Software fills it through a word-wide configuration write port.

Top module: `priv_io_guard`

## Requirements
- R1: A request presented with `req_valid` high at a clock edge produces `rsp_valid` high in the following cycle. `rsp_valid` is never high without such a request.
- R2: Class codes 1 (halt), 2 (control-register load), 3 (debug-register load) and 4 (descriptor-table base load) fault with cause 1 when `cpl` is not 0. They are allowed with cause 0 when `cpl` is 0. IOPL has no effect on them.
- R3: Class 5 (interrupt enable/disable) faults with cause 2 when `cpl` is numerically greater than `iopl`. Otherwise it is allowed with cause 0.
- R4: Class 6 (port input/output) faults with cause 3 exactly when the map bit for the port is 1. That bit is bit `port[3:0]` of map word `port[15:4]`. CPL and IOPL have no effect on this class.
- R5: Class 0 (no restriction) and class 7 (reserved) are always allowed with cause 0, at any CPL and IOPL.
- R6: When `cfg_we` is high at a clock edge, map word `cfg_addr` takes `cfg_data`. A port lookup requested at that same edge sees the word's previous contents. A lookup at the next edge sees the new contents.
- R7: After reset, and in any cycle with `rsp_valid` low, `rsp_allow`, `rsp_fault` and `rsp_cause` are all 0.
- R8: While `rsp_valid` is high, exactly one of `rsp_allow` and `rsp_fault` is high. `rsp_cause` is 0 exactly when `rsp_allow` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_class | input | 3 | Instruction class code |
| req_port | input | 16 | I/O port number (used by class 6) |
| req_cpl | input | 2 | Current privilege level |
| req_iopl | input | 2 | I/O privilege field from the flags register |
| cfg_we | input | 1 | Map word write enable |
| cfg_addr | input | 12 | Map word index |
| cfg_data | input | 16 | Map word data; bit n covers port index*16+n |
| rsp_valid | output | 1 | Decision valid |
| rsp_allow | output | 1 | Instruction may execute |
| rsp_fault | output | 1 | Instruction must fault |
| rsp_cause | output | 2 | 0 none, 1 needs CPL 0, 2 IOPL violation, 3 port protected |

## Verification
The bench sweeps every class against all sixteen CPL/IOPL pairs. This catches an inverted comparison or an off-by-one at CPL equal to IOPL: such a design would fault an interrupt instruction that should pass, or let one through that should fault. It fills the whole map with an irregular pattern and then probes ports whose neighbouring bits differ. Swapped word and bit fields, or a reversed bit order, would therefore give wrong port decisions. A lookup is aimed at a word in the same cycle that word is rewritten; a design that forwarded the new data would answer one cycle early. Random traffic mixes idle cycles and writes, which exposes outputs that leak while no decision is pending.

// File: rtl/piog_pkg.sv
// Shared encodings for the privileged instruction and I/O guard.
// Assumes the decoder and this block agree on the class codes below.
package piog_pkg;
    typedef enum logic [2:0] {
        CLS_FREE    = 3'd0,
        CLS_HALT    = 3'd1,
        CLS_CTRL_LD = 3'd2,
        CLS_DBG_LD  = 3'd3,
        CLS_TBL_LD  = 3'd4,
        CLS_INTFLAG = 3'd5,
        CLS_PORTIO  = 3'd6,
        CLS_RSVD    = 3'd7
    } icls_e;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_RING0 = 2'd1,
        CAUSE_IOPL  = 2'd2,
        CAUSE_PORT  = 2'd3
    } cause_e;
endpackage

// File: rtl/piog_bitmap.sv
// Per-port protection map: WORDS words of WORD_W bits, one bit per port.
// Writes land at the clock edge. The read is registered, so a lookup
// issued together with a write to the same word returns the old contents.
// The array is not reset; software must fill it before relying on it.
module piog_bitmap #(
    parameter int PORT_W = 16,
    parameter int SEL_W  = 4,
    localparam int ADDR_W = PORT_W - SEL_W,
    localparam int WORD_W = 1 << SEL_W,
    localparam int WORDS  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [PORT_W-1:0] rd_port,
    output logic              rd_bit
);
    logic [WORD_W-1:0] mem [WORDS];
    logic [ADDR_W-1:0] rd_word;
    logic [SEL_W-1:0]  rd_sel;

    assign rd_word = rd_port[PORT_W-1:SEL_W];
    assign rd_sel  = rd_port[SEL_W-1:0];

    // Store a configuration word.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Fetch the protection bit for the addressed port.
    always_ff @(posedge clk) begin
        rd_bit <= mem[rd_word][rd_sel];
    end
endmodule

// File: rtl/piog_rules.sv
// Combinational privilege rules for the non-port classes.
// Halt and the three table/register loads need CPL 0. Interrupt flag
// changes need CPL <= IOPL. Port I/O is left to the map and reports no
// fault here. Every other class passes.
module piog_rules
    import piog_pkg::*;
#(
    parameter int PL_W = 2
) (
    input  logic [2:0]      cls,
    input  logic [PL_W-1:0] cpl,
    input  logic [PL_W-1:0] iopl,
    output logic            fault,
    output logic [1:0]      cause
);
    // Pick the rule that governs the class and evaluate it.
    always_comb begin
        fault = 1'b0;
        cause = CAUSE_NONE;
        case (icls_e'(cls))
            CLS_HALT, CLS_CTRL_LD, CLS_DBG_LD, CLS_TBL_LD: begin
                if (cpl != '0) begin
                    fault = 1'b1;
                    cause = CAUSE_RING0;
                end
            end
            CLS_INTFLAG: begin
                if (cpl > iopl) begin
                    fault = 1'b1;
                    cause = CAUSE_IOPL;
                end
            end
            default: begin
                fault = 1'b0;
                cause = CAUSE_NONE;
            end
        endcase
    end
endmodule

// File: rtl/priv_io_guard.sv
// Top level: registers the rule decision for one cycle, so that it lines
// up with the registered map lookup. Every class then answers one cycle
// after its request. Outputs are held at zero when no decision is due.
module priv_io_guard
    import piog_pkg::*;
#(
    parameter int PORT_W = 16,
    parameter int SEL_W  = 4,
    parameter int PL_W   = 2,
    localparam int ADDR_W = PORT_W - SEL_W,
    localparam int WORD_W = 1 << SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_class,
    input  logic [PORT_W-1:0] req_port,
    input  logic [PL_W-1:0]   req_cpl,
    input  logic [PL_W-1:0]   req_iopl,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [WORD_W-1:0] cfg_data,
    output logic              rsp_valid,
    output logic              rsp_allow,
    output logic              rsp_fault,
    output logic [1:0]        rsp_cause
);
    logic       rule_fault, rule_fault_q;
    logic [1:0] rule_cause, rule_cause_q;
    logic       v_q, is_port_q, map_bit;
    logic       fault_sel;
    logic [1:0] cause_sel;

    piog_rules #(.PL_W(PL_W)) u_rules (
        .cls   (req_class),
        .cpl   (req_cpl),
        .iopl  (req_iopl),
        .fault (rule_fault),
        .cause (rule_cause)
    );

    piog_bitmap #(.PORT_W(PORT_W), .SEL_W(SEL_W)) u_map (
        .clk     (clk),
        .wr_en   (cfg_we),
        .wr_addr (cfg_addr),
        .wr_data (cfg_data),
        .rd_port (req_port),
        .rd_bit  (map_bit)
    );

    // Hold the request's rule outcome until the map bit arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q          <= 1'b0;
            is_port_q    <= 1'b0;
            rule_fault_q <= 1'b0;
            rule_cause_q <= CAUSE_NONE;
        end else begin
            v_q          <= req_valid;
            is_port_q    <= (req_class == CLS_PORTIO);
            rule_fault_q <= rule_fault;
            rule_cause_q <= rule_cause;
        end
    end

    // Merge the port decision with the rule decision.
    always_comb begin
        if (is_port_q) begin
            fault_sel = map_bit;
            cause_sel = map_bit ? CAUSE_PORT : CAUSE_NONE;
        end else begin
            fault_sel = rule_fault_q;
            cause_sel = rule_cause_q;
        end
    end

    assign rsp_valid = v_q;
    assign rsp_fault = v_q & fault_sel;
    assign rsp_allow = v_q & ~fault_sel;
    assign rsp_cause = v_q ? cause_sel : CAUSE_NONE;

    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rsp_valid == $past(req_valid)));

    assert_ring0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(req_valid) && $past(req_class) >= 3'd1
         && $past(req_class) <= 3'd4)
        |-> (rsp_fault == ($past(req_cpl) != '0))
            && (rsp_cause == ((($past(req_cpl) != '0)) ? 2'd1 : 2'd0)));

    assert_iopl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(req_valid) && $past(req_class) == 3'd5)
        |-> (rsp_fault == ($past(req_cpl) > $past(req_iopl))));

    assert_port_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(req_valid) && $past(req_class) == 3'd6 && rsp_fault)
        |-> rsp_cause == 2'd3);

    assert_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(req_valid)
         && ($past(req_class) == 3'd0 || $past(req_class) == 3'd7))
        |-> rsp_allow && rsp_cause == 2'd0);

    assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !rsp_allow && !rsp_fault && rsp_cause == 2'd0);

    assert_one_hot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $onehot({rsp_allow, rsp_fault}) && ((rsp_cause == 2'd0) == rsp_allow));
endmodule

// File: tb/priv_io_guard_bench.sv
module priv_io_guard_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_class = '0;
    logic [15:0] req_port = '0;
    logic [1:0]  req_cpl = '0, req_iopl = '0;
    logic        cfg_we = 1'b0;
    logic [11:0] cfg_addr = '0;
    logic [15:0] cfg_data = '0;
    logic        rsp_valid, rsp_allow, rsp_fault;
    logic [1:0]  rsp_cause;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    logic [15:0] mdl [4096];
    logic       e_valid = 1'b0, e_allow = 1'b0, e_fault = 1'b0;
    logic [1:0] e_cause = 2'd0;
    string      e_tag = "R7";

    always #2 clk = ~clk;

    priv_io_guard u_priv_io_guard (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_class(req_class),
        .req_port(req_port), .req_cpl(req_cpl), .req_iopl(req_iopl),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_fault(rsp_fault),
        .rsp_cause(rsp_cause)
    );

    task automatic check_now();
        total++;
        if (rsp_valid !== e_valid || rsp_allow !== e_allow ||
            rsp_fault !== e_fault || rsp_cause !== e_cause) begin
            bad++;
            $display("FAIL %s: got v=%b a=%b f=%b c=%0d expected v=%b a=%b f=%b c=%0d",
                     e_tag, rsp_valid, rsp_allow, rsp_fault, rsp_cause,
                     e_valid, e_allow, e_fault, e_cause);
        end
    endtask

    // One cycle: check last decision, drive new inputs, predict, update model.
    task automatic step(input logic v, input logic [2:0] c, input logic [15:0] p,
                        input logic [1:0] cp, input logic [1:0] io,
                        input logic we, input logic [11:0] wa, input logic [15:0] wd,
                        input string tag);
        @(negedge clk);
        check_now();
        req_valid = v; req_class = c; req_port = p; req_cpl = cp; req_iopl = io;
        cfg_we = we; cfg_addr = wa; cfg_data = wd;
        e_valid = v; e_fault = 1'b0; e_cause = 2'd0;
        if (v) begin
            if (c >= 3'd1 && c <= 3'd4) begin            // R2
                if (cp != 0) begin e_fault = 1'b1; e_cause = 2'd1; end
            end else if (c == 3'd5) begin                // R3
                if (cp > io) begin e_fault = 1'b1; e_cause = 2'd2; end
            end else if (c == 3'd6) begin                // R4, R6: old contents
                if (mdl[p[15:4]][p[3:0]]) begin e_fault = 1'b1; e_cause = 2'd3; end
            end
        end
        e_allow = v && !e_fault;
        e_tag = v ? tag : "R7";
        if (we) mdl[wa] = wd;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                bad++; total++;
                $display("FAIL watchdog: got hung run expected completion");
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        check_now();                                   // R7 reset state
        rst_n = 1'b1;
        // R6: fill the map with an irregular pattern
        for (int i = 0; i < 4096; i++)
            step(1'b0, 3'd0, 16'd0, 2'd0, 2'd0, 1'b1, 12'(i),
                 16'((i * 40503) ^ (i << 3) ^ 16'h5a3c), "R6");
        // R2 R3 R5 R4: every class against every CPL/IOPL pair
        for (int c = 0; c < 8; c++)
            for (int cp = 0; cp < 4; cp++)
                for (int io = 0; io < 4; io++)
                    step(1'b1, 3'(c), 16'($urandom), 2'(cp), 2'(io), 1'b0, 12'd0, 16'd0,
                         c == 6 ? "R4" : (c == 5 ? "R3" : ((c == 0 || c == 7) ? "R5" : "R2")));
        // R4: walk every bit of a few words
        for (int w = 0; w < 4; w++)
            for (int b = 0; b < 16; b++)
                step(1'b1, 3'd6, 16'((w * 977 % 4096) * 16 + b), 2'd3, 2'd0,
                     1'b0, 12'd0, 16'd0, "R4");
        // R6: lookup during a rewrite sees old word, then the new one
        step(1'b1, 3'd6, 16'h1234, 2'd0, 2'd3, 1'b1, 12'h123, 16'h0000, "R6");
        step(1'b1, 3'd6, 16'h1234, 2'd0, 2'd3, 1'b1, 12'h123, 16'hffff, "R6");
        step(1'b1, 3'd6, 16'h1234, 2'd0, 2'd3, 1'b0, 12'h0, 16'h0, "R6");
        step(1'b1, 3'd6, 16'h1230, 2'd0, 2'd3, 1'b1, 12'h123, 16'h0000, "R6");
        step(1'b1, 3'd6, 16'h123f, 2'd1, 2'd1, 1'b0, 12'h0, 16'h0, "R6");
        // R1 R7 R8: random mix with idle cycles and writes
        for (int n = 0; n < 4000; n++) begin
            logic [15:0] rp;
            rp = 16'($urandom);
            step(($urandom % 4) != 0, 3'($urandom), ($urandom % 3 == 0) ? {4'h1, rp[11:0]} : rp,
                 2'($urandom), 2'($urandom), ($urandom % 5) == 0,
                 ($urandom % 2) ? {4'h1, rp[11:4]} : 12'($urandom), 16'($urandom), "R1/R8");
        end
        step(1'b0, 3'd0, 16'd0, 2'd0, 2'd0, 1'b0, 12'd0, 16'd0, "R7");
        step(1'b0, 3'd0, 16'd0, 2'd0, 2'd0, 1'b0, 12'd0, 16'd0, "R7");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule